// File: doc/BRIEF.md
# NAND Flash Page Read Sequencer

This block sits on the controller side of a raw NAND flash device. It turns a single read request into the strobed bus cycles the flash expects. The bus is an 8-bit shared command/address/data path with command-latch, address-latch, write-strobe, read-strobe and chip-enable lines, and a ready/busy return line.

A full page read sends the open command, five address bytes and the confirm command. It then waits until the flash reports ready and streams the requested bytes out on a valid/ready interface. A random data-out request is cheaper. It sends a different command pair around only the two column bytes and starts streaming at once from the page already held in the flash's register.

Every request ends with a one-cycle completion pulse that carries an error bit. The error bit is set in three cases: the request is malformed, the request falls outside the page, or the ready/busy wait times out.

Top module: `nand_rd_top`

## Requirements
- R1: A page read drives, in this order, a command cycle carrying 00h, five address cycles, and a command cycle carrying 30h. The address cycles carry column bits [7:0], column bits [15:8], then row bits [7:0], [15:8] and [23:16]. Each byte is held steady while the write strobe is low and is latched by the flash on the strobe's rising edge.
- R2: After the 30h confirm, no read strobe is issued while ready/busy is low. The first read strobe follows the flash's busy period. If ready/busy does not return high within BUSY_LIMIT cycles, the request completes with the error bit set and delivers no bytes.
- R3: The first delivered byte is the byte at the requested column, and each later byte comes from the next column. Exactly the requested count is delivered. While outValid is high and outReady is low, outData holds steady and no further read strobe is issued.
- R4: The controller drives the shared bus only during command and address cycles. Its output enable is never high while the read strobe is low.
- R5: A request with a count of zero, or whose column plus count exceeds PAGE_BYTES (2112), completes with the error bit set and produces no bus cycles.
- R6: A random data-out request drives a command cycle carrying 05h, the two column bytes (low byte first), and a command cycle carrying E0h. Streaming then starts without any ready/busy wait.
- R7: A random data-out request is accepted only if the most recent page read completed without error. Otherwise it completes with the error bit set and produces no bus cycles.
- R8: The command-latch line is high only during command cycles and the address-latch line only during address cycles. The two are never high together, and neither is high during a read strobe.
- R9: Every write-strobe low pulse lasts exactly WE_LO cycles and every read-strobe low pulse exactly RE_LO cycles. The high time between consecutive pulses is at least WE_HI or RE_HI cycles.
- R10: Chip enable is low from the first command cycle through the last delivered byte, and high whenever the block is idle. reqReady is high only while idle.
- R11: During and right after reset, chip enable, the write strobe and the read strobe are high, both latch lines are low, the bus is not driven, outValid is low and reqReady is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request taken this cycle |
| reqRandom | input | 1 | 1 = random data-out within loaded page, 0 = full page read |
| reqRow | input | 24 | Row (page) address |
| reqCol | input | 16 | Starting column |
| reqCount | input | 16 | Number of bytes to deliver |
| doneValid | output | 1 | One-cycle completion pulse |
| doneErr | output | 1 | Error bit, valid with doneValid |
| outValid | output | 1 | Data byte available |
| outReady | input | 1 | Consumer accepts the byte |
| outData | output | 8 | Data byte |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandIoOut | output | 8 | Bus value driven by the controller |
| nandIoOe | output | 1 | Bus output enable |
| nandIoIn | input | 8 | Bus value driven by the flash |
| nandRb | input | 1 | Ready (1) / busy (0) |

## Verification
The bench targets reads that end exactly on the last byte of the page, reads that overrun the page by one byte, and zero-length requests. A design with an off-by-one range check would either reject the legal read or stream invalid bytes past the end. Random data-out is tried before any page read, right after a timed-out page read, and after a rejected request. A controller that gated it on the wrong condition would issue bus cycles it should have refused, or refuse a legal access. A flash model that holds busy low forces the timeout path, and a bursty consumer exercises backpressure. Together these expose a sequencer that strobes reads during busy, drops or repeats bytes when stalled, or mis-orders the address bytes.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;
  localparam int IO_W  = 8;
  localparam int ROW_W = 24;
  localparam int COL_W = 16;

  localparam logic [IO_W-1:0] OP_PAGE_OPEN = 8'h00;
  localparam logic [IO_W-1:0] OP_PAGE_GO   = 8'h30;
  localparam logic [IO_W-1:0] OP_RAND_OPEN = 8'h05;
  localparam logic [IO_W-1:0] OP_RAND_GO   = 8'hE0;

  // Which byte the controller places on the bus during a write cycle.
  typedef enum logic [3:0] {
    SEL_COL_LO, SEL_COL_HI, SEL_ROW_0, SEL_ROW_1, SEL_ROW_2,
    SEL_PAGE_OPEN, SEL_PAGE_GO, SEL_RAND_OPEN, SEL_RAND_GO
  } byteSel_e;

  // Strobes from the control FSM to the pin-side datapath.
  typedef struct packed {
    logic     cle;
    logic     ale;
    logic     weLow;
    logic     reLow;
    logic     ceLow;
    logic     drive;
    logic     load;
    logic     capture;
    byteSel_e byteSel;
  } busCtl_t;
endpackage

// File: rtl/nand_rd_datapath.sv
module nand_rd_datapath
  import nand_rd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  busCtl_t          ctl,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [COL_W-1:0] reqCol,
  input  logic [IO_W-1:0]  nandIoIn,
  output logic [IO_W-1:0]  nandIoOut,
  output logic             nandIoOe,
  output logic             nandCeN,
  output logic             nandCle,
  output logic             nandAle,
  output logic             nandWeN,
  output logic             nandReN,
  output logic [IO_W-1:0]  outData
);
  localparam int ROW_BYTES = ROW_W / IO_W;

  logic [ROW_W-1:0] rowQ;
  logic [COL_W-1:0] colQ;
  logic [IO_W-1:0]  dataQ;
  logic [IO_W-1:0]  rowByte [ROW_BYTES];
  logic [IO_W-1:0]  busByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ  <= '0;
      colQ  <= '0;
      dataQ <= '0;
    end else begin
      if (ctl.load) begin
        rowQ <= reqRow;
        colQ <= reqCol;
      end
      if (ctl.capture) dataQ <= nandIoIn;
    end
  end

  for (genvar i = 0; i < ROW_BYTES; i++) begin : g_rowByte
    assign rowByte[i] = rowQ[i*IO_W +: IO_W];
  end

  always_comb begin
    unique case (ctl.byteSel)
      SEL_COL_LO:    busByte = colQ[IO_W-1:0];
      SEL_COL_HI:    busByte = colQ[COL_W-1:IO_W];
      SEL_ROW_0:     busByte = rowByte[0];
      SEL_ROW_1:     busByte = rowByte[1];
      SEL_ROW_2:     busByte = rowByte[2];
      SEL_PAGE_OPEN: busByte = OP_PAGE_OPEN;
      SEL_PAGE_GO:   busByte = OP_PAGE_GO;
      SEL_RAND_OPEN: busByte = OP_RAND_OPEN;
      SEL_RAND_GO:   busByte = OP_RAND_GO;
      default:       busByte = '0;
    endcase
  end

  assign nandIoOut = ctl.drive ? busByte : '0;
  assign nandIoOe  = ctl.drive;
  assign nandCeN   = ~ctl.ceLow;
  assign nandCle   = ctl.cle;
  assign nandAle   = ctl.ale;
  assign nandWeN   = ~ctl.weLow;
  assign nandReN   = ~ctl.reLow;
  assign outData   = dataQ;
endmodule

// File: rtl/nand_rd_ctrl.sv
module nand_rd_ctrl
  import nand_rd_pkg::*;
#(
  parameter int PAGE_BYTES = 2112,
  parameter int WE_LO      = 2,
  parameter int WE_HI      = 2,
  parameter int RE_LO      = 2,
  parameter int RE_HI      = 2,
  parameter int BUSY_GUARD = 4,
  parameter int BUSY_LIMIT = 20000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqRandom,
  input  logic [COL_W-1:0] reqCol,
  input  logic [COL_W-1:0] reqCount,
  input  logic             nandRb,
  input  logic             outReady,
  output logic             reqReady,
  output logic             outValid,
  output logic             doneValid,
  output logic             doneErr,
  output busCtl_t          ctl
);
  localparam int WR_LEN = WE_LO + WE_HI;
  localparam int PH_W   = $clog2(WR_LEN + RE_LO + RE_HI + 1);
  localparam int WT_W   = $clog2(BUSY_LIMIT + 1);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_BUSY, S_RLO, S_PUSH, S_RHI, S_DONE} state_e;

  state_e           state;
  logic [PH_W-1:0]  phase;
  logic [2:0]       stepIdx;
  logic [WT_W-1:0]  waitCnt;
  logic [COL_W-1:0] remain;
  logic             isRandom, errQ, lastOk;
  logic [2:0]       lastStep;
  logic [COL_W:0]   endCol;
  logic             badReq;

  assign lastStep = isRandom ? 3'd3 : 3'd6;
  assign endCol   = {1'b0, reqCol} + {1'b0, reqCount};
  assign badReq   = (reqCount == '0) || (endCol > (COL_W+1)'(PAGE_BYTES)) ||
                    (reqRandom && !lastOk);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; phase <= '0; stepIdx <= '0; waitCnt <= '0;
      remain <= '0; isRandom <= 1'b0; errQ <= 1'b0; lastOk <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (reqValid) begin
          if (badReq) begin
            errQ  <= 1'b1;
            state <= S_DONE;
          end else begin
            isRandom <= reqRandom;
            remain   <= reqCount;
            errQ     <= 1'b0;
            stepIdx  <= '0;
            phase    <= '0;
            state    <= S_WR;
          end
        end
        S_WR: if (phase == PH_W'(WR_LEN - 1)) begin
          phase <= '0;
          if (stepIdx == lastStep) begin
            waitCnt <= '0;
            state   <= isRandom ? S_RLO : S_BUSY;
          end else stepIdx <= stepIdx + 3'd1;
        end else phase <= phase + 1'b1;
        S_BUSY: begin
          waitCnt <= waitCnt + 1'b1;
          if (waitCnt >= WT_W'(BUSY_GUARD) && nandRb) begin
            phase <= '0;
            state <= S_RLO;
          end else if (waitCnt == WT_W'(BUSY_LIMIT - 1)) begin
            errQ   <= 1'b1;
            lastOk <= 1'b0;
            state  <= S_DONE;
          end
        end
        S_RLO: if (phase == PH_W'(RE_LO - 1)) begin
          phase <= '0;
          state <= S_PUSH;
        end else phase <= phase + 1'b1;
        S_PUSH: if (outReady) begin
          if (remain == COL_W'(1)) state <= S_DONE;
          else begin
            remain <= remain - 1'b1;
            phase  <= '0;
            state  <= S_RHI;
          end
        end
        S_RHI: if (phase == PH_W'(RE_HI - 1)) begin
          phase <= '0;
          state <= S_RLO;
        end else phase <= phase + 1'b1;
        S_DONE: begin
          if (!errQ && !isRandom) lastOk <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl = '0;
    ctl.byteSel = SEL_COL_LO;
    ctl.load    = (state == S_IDLE) && reqValid && !badReq;
    ctl.ceLow   = (state != S_IDLE) && (state != S_DONE);
    ctl.capture = (state == S_RLO) && (phase == PH_W'(RE_LO - 1));
    ctl.reLow   = (state == S_RLO);
    if (state == S_WR) begin
      if (stepIdx == 3'd0)
        ctl.byteSel = isRandom ? SEL_RAND_OPEN : SEL_PAGE_OPEN;
      else if (stepIdx == lastStep)
        ctl.byteSel = isRandom ? SEL_RAND_GO : SEL_PAGE_GO;
      else
        ctl.byteSel = byteSel_e'({1'b0, stepIdx - 3'd1});
      ctl.drive = 1'b1;
      ctl.weLow = (phase < PH_W'(WE_LO));
      ctl.cle   = (ctl.byteSel >= SEL_PAGE_OPEN);
      ctl.ale   = (ctl.byteSel <  SEL_PAGE_OPEN);
    end
  end

  assign reqReady  = (state == S_IDLE);
  assign outValid  = (state == S_PUSH);
  assign doneValid = (state == S_DONE);
  assign doneErr   = errQ;
endmodule

// File: rtl/nand_rd_top.sv
module nand_rd_top
  import nand_rd_pkg::*;
#(
  parameter int PAGE_BYTES = 2112,
  parameter int WE_LO      = 2,
  parameter int WE_HI      = 2,
  parameter int RE_LO      = 2,
  parameter int RE_HI      = 2,
  parameter int BUSY_GUARD = 4,
  parameter int BUSY_LIMIT = 20000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqRandom,
  input  logic [23:0] reqRow,
  input  logic [15:0] reqCol,
  input  logic [15:0] reqCount,
  output logic        doneValid,
  output logic        doneErr,
  output logic        outValid,
  input  logic        outReady,
  output logic [7:0]  outData,
  output logic        nandCeN,
  output logic        nandCle,
  output logic        nandAle,
  output logic        nandWeN,
  output logic        nandReN,
  output logic [7:0]  nandIoOut,
  output logic        nandIoOe,
  input  logic [7:0]  nandIoIn,
  input  logic        nandRb
);
  busCtl_t ctl;

  nand_rd_ctrl #(
    .PAGE_BYTES(PAGE_BYTES), .WE_LO(WE_LO), .WE_HI(WE_HI), .RE_LO(RE_LO),
    .RE_HI(RE_HI), .BUSY_GUARD(BUSY_GUARD), .BUSY_LIMIT(BUSY_LIMIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRandom(reqRandom),
    .reqCol(reqCol), .reqCount(reqCount), .nandRb(nandRb), .outReady(outReady),
    .reqReady(reqReady), .outValid(outValid), .doneValid(doneValid),
    .doneErr(doneErr), .ctl(ctl)
  );

  nand_rd_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqRow(reqRow), .reqCol(reqCol),
    .nandIoIn(nandIoIn), .nandIoOut(nandIoOut), .nandIoOe(nandIoOe),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .outData(outData)
  );
endmodule

// File: rtl/nand_rd_checker.sv
module nand_rd_checker #(
  parameter int WE_LO = 2,
  parameter int RE_LO = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       reqReady,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outData,
  input logic       nandCeN,
  input logic       nandCle,
  input logic       nandAle,
  input logic       nandWeN,
  input logic       nandReN,
  input logic [7:0] nandIoOut,
  input logic       nandIoOe
);
  logic [7:0] weLowCnt, reLowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weLowCnt <= '0;
      reLowCnt <= '0;
    end else begin
      weLowCnt <= nandWeN ? 8'd0 : ((weLowCnt == 8'hFF) ? weLowCnt : weLowCnt + 8'd1);
      reLowCnt <= nandReN ? 8'd0 : ((reLowCnt == 8'hFF) ? reLowCnt : reLowCnt + 8'd1);
    end
  end

  // R8
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle) && !(!nandReN && (nandCle || nandAle)));

  // R4
  bus_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> !nandIoOe);

  // R9
  we_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandWeN) |-> weLowCnt == 8'(WE_LO));

  // R9
  re_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandReN) |-> reLowCnt == 8'(RE_LO));

  // R10
  ce_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> nandCeN);

  // R10
  ce_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN || !nandReN) |-> !nandCeN);

  // R3
  hold_stream_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && nandReN);

  // R1
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !nandWeN && $past(!nandWeN) |-> $stable(nandIoOut) && $stable(nandCle) && $stable(nandAle));
endmodule

bind nand_rd_top nand_rd_checker #(.WE_LO(WE_LO), .RE_LO(RE_LO)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .outValid(outValid),
  .outReady(outReady), .outData(outData), .nandCeN(nandCeN), .nandCle(nandCle),
  .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
  .nandIoOut(nandIoOut), .nandIoOe(nandIoOe)
);

// File: tb/sim_nand_rd_top.sv
`timescale 1ns/1ps
module sim_nand_rd_top;
  localparam int WE_LO = 2, WE_HI = 1, RE_LO = 2, RE_HI = 1;
  localparam int BUSY_LIMIT = 200, BUSY_CYC = 60;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqRandom = 1'b0, outReady = 1'b0;
  logic [23:0] reqRow = '0;
  logic [15:0] reqCol = '0, reqCount = '0;
  logic reqReady, doneValid, doneErr, outValid;
  logic [7:0] outData, nandIoOut, nandIoIn;
  logic nandCeN, nandCle, nandAle, nandWeN, nandReN, nandIoOe;
  logic nandRb;

  always #2.5 clk = ~clk;

  nand_rd_top #(.WE_LO(WE_LO), .WE_HI(WE_HI), .RE_LO(RE_LO), .RE_HI(RE_HI),
                .BUSY_GUARD(4), .BUSY_LIMIT(BUSY_LIMIT)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqRandom(reqRandom), .reqRow(reqRow), .reqCol(reqCol), .reqCount(reqCount),
    .doneValid(doneValid), .doneErr(doneErr), .outValid(outValid),
    .outReady(outReady), .outData(outData), .nandCeN(nandCeN), .nandCle(nandCle),
    .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN), .nandIoOut(nandIoOut),
    .nandIoOe(nandIoOe), .nandIoIn(nandIoIn), .nandRb(nandRb)
  );

  int checks = 0, errors = 0;

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [23:0] row, input logic [15:0] col);
    return (col[7:0] + 8'(col[11:8] * 8'd17)) ^ row[7:0] ^ row[15:8];
  endfunction

  // ---------------- flash model and bus monitor (negedge) ----------------
  logic [7:0] cmdLog [8];
  logic [7:0] addrLog [8];
  int cmdN = 0, addrN = 0, weRises = 0;
  int weWidthBad = 0, reWidthBad = 0, busViol = 0, strobeViol = 0, ceViol = 0, readBusyViol = 0;
  int weRun = 0, reRun = 0, gapCnt = 0, firstReGap = -1;
  logic gapArmed = 1'b0, prevWe = 1'b1, prevRe = 1'b1, holdBusy = 1'b0;
  logic [23:0] rowM = '0;
  logic [15:0] colPtr = '0;
  int busyCnt = 0;

  assign nandRb   = !holdBusy && (busyCnt == 0);
  assign nandIoIn = !nandReN ? pat(rowM, colPtr) : 8'h00;

  always @(negedge clk) begin
    if (rstN) begin
      if (busyCnt > 0) busyCnt--;
      if (!nandWeN) weRun++;
      if (!nandReN) reRun++;
      if (nandWeN && !prevWe) begin
        weRises++;
        if (weRun != WE_LO) weWidthBad++;
        weRun = 0;
        gapArmed = 1'b1; gapCnt = 0; firstReGap = -1;
        if (nandCle && cmdN < 8) begin
          cmdLog[cmdN] = nandIoOut; cmdN++;
          if (nandIoOut == 8'h30) begin
            busyCnt = BUSY_CYC;
            colPtr = {addrLog[1], addrLog[0]};
            rowM = {addrLog[4], addrLog[3], addrLog[2]};
          end
          if (nandIoOut == 8'hE0) colPtr = {addrLog[1], addrLog[0]};
        end
        if (nandAle && addrN < 8) begin addrLog[addrN] = nandIoOut; addrN++; end
      end else if (gapArmed) begin
        gapCnt++;
        if (!nandReN) begin firstReGap = gapCnt; gapArmed = 1'b0; end
      end
      if (nandReN && !prevRe) begin
        if (reRun != RE_LO) reWidthBad++;
        reRun = 0;
        colPtr++;
      end
      if (nandIoOe && !nandReN) busViol++;
      if ((nandCle && nandAle) || (!nandReN && (nandCle || nandAle))) strobeViol++;
      if (nandCeN && (!nandWeN || !nandReN)) ceViol++;
      if (!nandReN && !nandRb) readBusyViol++;
      prevWe = nandWeN;
      prevRe = nandReN;
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- request runner ----------------
  logic [23:0] bRow = '0;

  task automatic runReq(input logic rnd, input logic [23:0] row, input logic [15:0] col,
                        input logic [15:0] cnt, input logic expErr, input logic expBus,
                        input string tag);
    int got = 0, bad = 0, guard = 0, tick = 0;
    logic gotErr = 1'b0;
    logic [23:0] eRow;
    eRow = rnd ? bRow : row;
    cmdN = 0; addrN = 0; weRises = 0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqRandom = rnd; reqRow = row; reqCol = col; reqCount = cnt;
    @(negedge clk);
    reqValid = 1'b0;
    while (!doneValid && guard < 5000) begin
      if (outValid && outReady) begin
        if (outData != pat(eRow, col + 16'(got))) bad++;
        got++;
      end
      tick++;
      outReady = (tick % 3) != 0;
      @(negedge clk);
      guard++;
    end
    gotErr = doneErr;
    check(doneValid && gotErr == expErr, tag, gotErr, expErr);
    if (!expBus) check(weRises == 0, tag, weRises, 0);
    else if (rnd) begin
      // R6: 05h, column low, column high, E0h; no busy wait
      check(cmdN == 2 && cmdLog[0] == 8'h05 && cmdLog[1] == 8'hE0, "R6",
            {cmdLog[0], cmdLog[1]}, 16'h05E0);
      check(addrN == 2 && {addrLog[1], addrLog[0]} == col, "R6", {addrLog[1], addrLog[0]}, col);
      if (!expErr) check(firstReGap >= 1 && firstReGap <= 3, "R6", firstReGap, 1);
    end else begin
      // R1: 00h, col lo, col hi, row0..2, 30h
      check(cmdN == 2 && cmdLog[0] == 8'h00 && cmdLog[1] == 8'h30, "R1",
            {cmdLog[0], cmdLog[1]}, 16'h0030);
      check(addrN == 5 && {addrLog[4], addrLog[3], addrLog[2], addrLog[1], addrLog[0]} == {row, col},
            "R1", {addrLog[4], addrLog[3], addrLog[2], addrLog[1], addrLog[0]}, {row, col});
      if (!expErr) check(firstReGap >= BUSY_CYC, "R2", firstReGap, BUSY_CYC);
    end
    if (!expErr) begin
      check(got == int'(cnt), "R3", got, cnt);
      check(bad == 0, "R3", bad, 0);
      if (!rnd) bRow = row;
    end else check(got == 0, tag, got, 0);
    outReady = 1'b0;
  endtask

  typedef struct packed {
    logic        rnd;
    logic [23:0] row;
    logic [15:0] col;
    logic [15:0] cnt;
    logic        expErr;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{1'b1, 24'h000000, 16'd0,    16'd1, 1'b1},   // random before any page: R7
    '{1'b0, 24'h012345, 16'd0,    16'd4, 1'b0},   // plain page read
    '{1'b1, 24'h000000, 16'd100,  16'd3, 1'b0},   // random in loaded page
    '{1'b0, 24'h0A0B0C, 16'd2108, 16'd4, 1'b0},   // ends on last byte
    '{1'b0, 24'h0A0B0C, 16'd2109, 16'd4, 1'b1},   // overruns by one: R5
    '{1'b1, 24'h000000, 16'd2111, 16'd1, 1'b0},   // last byte via random
    '{1'b0, 24'h111111, 16'd5,    16'd0, 1'b1}    // zero count: R5
  };

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    check(nandCeN && nandWeN && nandReN && !nandCle && !nandAle && !nandIoOe &&
          !outValid && reqReady, "R11",
          {nandCeN, nandWeN, nandReN, nandCle, nandAle, nandIoOe, outValid, reqReady}, 8'b11100001);
    rstN = 1'b1;
    @(negedge clk);
    check(nandCeN && nandWeN && nandReN && reqReady && !doneValid, "R11",
          {nandCeN, nandWeN, nandReN, reqReady}, 4'b1111);

    for (int i = 0; i <= 6; i++) begin
      runReq(VECS[i].rnd, VECS[i].row, VECS[i].col, VECS[i].cnt, VECS[i].expErr,
             !VECS[i].expErr, VECS[i].rnd ? "R7" : "R5");
    end

    // R2: flash never leaves busy -> timeout error
    holdBusy = 1'b1;
    runReq(1'b0, 24'h000777, 16'd10, 16'd2, 1'b1, 1'b1, "R2");
    holdBusy = 1'b0;
    // R7: random after a failed page read is refused
    runReq(1'b1, 24'h0, 16'd10, 16'd2, 1'b1, 1'b0, "R7");
    // recovery, then random works again with a longer stalled burst
    runReq(1'b0, 24'h00BEEF, 16'd300, 16'd9, 1'b0, 1'b1, "R3");
    runReq(1'b1, 24'h0, 16'd2000, 16'd6, 1'b0, 1'b1, "R6");

    repeat (3) @(negedge clk);
    check(weWidthBad == 0, "R9", weWidthBad, 0);
    check(reWidthBad == 0, "R9", reWidthBad, 0);
    check(busViol == 0, "R4", busViol, 0);
    check(strobeViol == 0, "R8", strobeViol, 0);
    check(ceViol == 0 && nandCeN && reqReady, "R10", ceViol, 0);
    check(readBusyViol == 0, "R2", readBusyViol, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule